// File: doc/BRIEF.md
# 16-bit Reload/Capture Timer

This block is a 16-bit up-counter that works in one of two wide modes, chosen by a capture-mode control. In reload mode the counter runs until it passes the all-ones value. It then restarts from a software-programmed reload value instead of zero. This gives a periodic overflow at a chosen rate. In capture mode the counter runs freely and wraps to zero. A selected edge on an external input copies the live count into the same 16-bit register that holds the reload value in the other mode, so software can measure intervals between edges.

The counter advances on a count tick. The tick comes from one of four single-cycle enable sources: every system clock cycle, one cycle in twelve, a fast real-time tick input, or a slow real-time pulse input. A run control stops counting. Two sticky flags, high and low, record events until software clears them by writing a one. An interrupt request output combines the two flags. Software loads the counter and the reload register one byte at a time through simple write strobes.

Top module: `rcap_timer`

## Requirements
- R1: After reset the counter, the reload/capture register, both flags and the interrupt request are all zero.
- R2: `cfg_clk_sel` picks the count tick: 0 every clock cycle, 1 one cycle in twelve from a free-running prescaler started at reset, 2 `rt_fast_tick`, 3 `rt_slow_tick`. The counter advances by exactly one on each tick while `cfg_run` is 1.
- R3: In reload mode (`cfg_cap_mode`=0), a tick taken at count 0xFFFF loads the reload register into the counter and sets the high flag.
- R4: In reload mode, a tick taken while the low byte is 0xFF sets the low flag. This includes the 0xFFFF case.
- R5: In capture mode (`cfg_cap_mode`=1), a capture event copies the current count into the reload/capture register and sets the high flag. `cap_in` passes a two-flop synchronizer and an edge register. A change on `cap_in` therefore takes effect at the third rising clock edge after it, latching the count held just before that edge.
- R6: In capture mode, a tick taken at 0xFFFF wraps the counter to 0x0000 and sets the low flag. No reload takes place.
- R7: `cfg_edge_sel` bit 0 enables rising edges and bit 1 enables falling edges. Value 3 captures on both edges and value 0 on none. Edges have no effect in reload mode.
- R8: While `cfg_run` is 0 the counter holds its value. In capture mode a capture event still latches the count and sets the high flag.
- R9: A capture event in the same cycle as a reload-register byte write wins, and the write is lost. A flag set in the same cycle as its clear leaves the flag set.
- R10: `irq` = `cfg_irq_en` AND (high flag OR (low flag AND `cfg_lo_irq_en`)).
- R11: Each flag stays set until a cycle with its clear strobe (`clr_flag_hi` / `clr_flag_lo`) high.
- R12: The byte strobes `wr_cnt_lo`, `wr_cnt_hi`, `wr_rld_lo`, `wr_rld_hi` load `wr_data` into bits 7:0 or 15:8 of the counter or reload register. A cycle with a counter write takes no count tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rt_fast_tick | input | 1 | Fast real-time single-cycle enable (source 2) |
| rt_slow_tick | input | 1 | Slow real-time single-cycle enable (source 3) |
| cap_in | input | 1 | External capture input, asynchronous |
| cfg_clk_sel | input | 2 | Count tick source select |
| cfg_run | input | 1 | Counting enable |
| cfg_cap_mode | input | 1 | 0 reload mode, 1 capture mode |
| cfg_edge_sel | input | 2 | Capture edge enables: bit 0 rising, bit 1 falling |
| cfg_lo_irq_en | input | 1 | Lets the low flag reach the interrupt request |
| cfg_irq_en | input | 1 | Global timer interrupt enable |
| wr_data | input | 8 | Byte for register writes |
| wr_cnt_lo | input | 1 | Write counter bits 7:0 |
| wr_cnt_hi | input | 1 | Write counter bits 15:8 |
| wr_rld_lo | input | 1 | Write reload register bits 7:0 |
| wr_rld_hi | input | 1 | Write reload register bits 15:8 |
| clr_flag_hi | input | 1 | Clear the high flag |
| clr_flag_lo | input | 1 | Clear the low flag |
| cnt_val | output | 16 | Current count |
| rld_val | output | 16 | Reload value / captured count |
| flag_hi | output | 1 | High flag (overflow or capture) |
| flag_lo | output | 1 | Low flag (low-byte wrap or full wrap) |
| irq | output | 1 | Interrupt request |

## Verification
All state sits on the outputs. A wrong count or a wrong reload load shows on `cnt_val` at the clock edge that follows the faulty tick. A wrong prescaler phase or synchronizer depth shows one tick, or one capture, later than expected. A flag set at the wrong time or lost too early shows on `flag_hi`/`flag_lo` and on `irq` in the same cycle. A model of the requirements running in lockstep compares every output in every cycle, so any divergence is reported within one cycle of its cause.

// File: rtl/rcap_timer_pkg.sv
package rcap_timer_pkg;

  typedef enum logic [1:0] {
    TSRC_SYS  = 2'd0,
    TSRC_DIV  = 2'd1,
    TSRC_FAST = 2'd2,
    TSRC_SLOW = 2'd3
  } tsrc_e;

  localparam int EDGE_RISE_BIT = 0;
  localparam int EDGE_FALL_BIT = 1;

  typedef struct packed {
    logic hi;
    logic lo;
  } flag_pair_t;

endpackage

// File: rtl/rcap_rst_sync.sv
module rcap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rcap_tick_sel.sv
module rcap_tick_sel
  import rcap_timer_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       rt_fast,
  input  logic       rt_slow,
  output logic       tick
);

  logic div_tick;

  generate
    if (DIV > 1) begin : g_prescale
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] pre_q;
      logic [PW-1:0] pre_d;

      always_comb begin
        if (pre_q == LAST) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + PW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign div_tick = (pre_q == LAST);
    end else begin : g_no_prescale
      assign div_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    case (tsrc_e'(sel))
      TSRC_SYS:  tick = 1'b1;
      TSRC_DIV:  tick = div_tick;
      TSRC_FAST: tick = rt_fast;
      TSRC_SLOW: tick = rt_slow;
      default:   tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/rcap_edge_det.sv
module rcap_edge_det
  import rcap_timer_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       evt
);

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            rise;
  logic            fall;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  always_comb begin
    rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    evt  = (rise & edge_sel[EDGE_RISE_BIT]) | (fall & edge_sel[EDGE_FALL_BIT]);
  end

endmodule

// File: rtl/rcap_core.sv
module rcap_core
  import rcap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               cap_evt,
  input  logic               cap_mode,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               wr_cnt_lo,
  input  logic               wr_cnt_hi,
  input  logic               wr_rld_lo,
  input  logic               wr_rld_hi,
  input  logic               clr_hi,
  input  logic               clr_lo,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   rld_q,
  output flag_pair_t         flags_q
);

  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] rld_d;
  logic [CNT_W-1:0] cnt_inc;
  flag_pair_t       flags_d;
  logic             cnt_wr;
  logic             adv;
  logic             cnt_full;
  logic             lo_full;
  logic             capture;
  logic             set_hi;
  logic             set_lo;

  always_comb begin
    cnt_inc  = cnt_q + CNT_W'(1);
    cnt_full = &cnt_q;
    lo_full  = &cnt_q[HALF-1:0];
    cnt_wr   = wr_cnt_lo | wr_cnt_hi;
    adv      = step & ~cnt_wr;
    capture  = cap_evt & cap_mode;

    cnt_d = cnt_q;
    if (cnt_wr) begin
      if (wr_cnt_lo) cnt_d[HALF-1:0]     = wr_data;
      if (wr_cnt_hi) cnt_d[CNT_W-1:HALF] = wr_data;
    end else if (adv) begin
      if (!cap_mode && cnt_full) begin
        cnt_d = rld_q;
      end else begin
        cnt_d = cnt_inc;
      end
    end

    rld_d = rld_q;
    if (capture) begin
      rld_d = cnt_q;
    end else begin
      if (wr_rld_lo) rld_d[HALF-1:0]     = wr_data;
      if (wr_rld_hi) rld_d[CNT_W-1:HALF] = wr_data;
    end

    set_hi = capture | (adv & ~cap_mode & cnt_full);
    set_lo = adv & (cap_mode ? cnt_full : lo_full);

    flags_d.hi = set_hi | (flags_q.hi & ~clr_hi);
    flags_d.lo = set_lo | (flags_q.lo & ~clr_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rld_q   <= '0;
      flags_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      rld_q   <= rld_d;
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/rcap_timer.sv
module rcap_timer
  import rcap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rt_fast_tick,
  input  logic               rt_slow_tick,
  input  logic               cap_in,
  input  logic [1:0]         cfg_clk_sel,
  input  logic               cfg_run,
  input  logic               cfg_cap_mode,
  input  logic [1:0]         cfg_edge_sel,
  input  logic               cfg_lo_irq_en,
  input  logic               cfg_irq_en,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic               wr_cnt_lo,
  input  logic               wr_cnt_hi,
  input  logic               wr_rld_lo,
  input  logic               wr_rld_hi,
  input  logic               clr_flag_hi,
  input  logic               clr_flag_lo,
  output logic [CNT_W-1:0]   cnt_val,
  output logic [CNT_W-1:0]   rld_val,
  output logic               flag_hi,
  output logic               flag_lo,
  output logic               irq
);

  logic       core_rst_n;
  logic       tick;
  logic       step;
  logic       cap_evt;
  flag_pair_t flags;

  rcap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  rcap_tick_sel #(.DIV(PRESCALE)) u_tick (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .sel     (cfg_clk_sel),
    .rt_fast (rt_fast_tick),
    .rt_slow (rt_slow_tick),
    .tick    (tick)
  );

  rcap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .din      (cap_in),
    .edge_sel (cfg_edge_sel),
    .evt      (cap_evt)
  );

  assign step = cfg_run & tick;

  rcap_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .step      (step),
    .cap_evt   (cap_evt),
    .cap_mode  (cfg_cap_mode),
    .wr_data   (wr_data),
    .wr_cnt_lo (wr_cnt_lo),
    .wr_cnt_hi (wr_cnt_hi),
    .wr_rld_lo (wr_rld_lo),
    .wr_rld_hi (wr_rld_hi),
    .clr_hi    (clr_flag_hi),
    .clr_lo    (clr_flag_lo),
    .cnt_q     (cnt_val),
    .rld_q     (rld_val),
    .flags_q   (flags)
  );

  assign flag_hi = flags.hi;
  assign flag_lo = flags.lo;
  assign irq     = cfg_irq_en & (flags.hi | (flags.lo & cfg_lo_irq_en));

endmodule

// File: rtl/rcap_timer_chk.sv
module rcap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_run,
  input logic             cfg_cap_mode,
  input logic             cfg_irq_en,
  input logic             wr_cnt_lo,
  input logic             wr_cnt_hi,
  input logic             clr_flag_hi,
  input logic             step,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] rld_val,
  input logic             flag_hi,
  input logic             flag_lo,
  input logic             irq
);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cfg_cap_mode && !wr_cnt_lo && !wr_cnt_hi && (&cnt_val))
    |=> (cnt_val == $past(rld_val)) && flag_hi);

  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cfg_cap_mode) |=> (rld_val == $past(cnt_val)) && flag_hi);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cfg_cap_mode && !wr_cnt_lo && !wr_cnt_hi && (&cnt_val))
    |=> (cnt_val == '0) && flag_lo);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt_val));

  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_irq_en |-> !irq);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_hi || flag_lo));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !clr_flag_hi) |=> flag_hi);

endmodule

bind rcap_timer rcap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_run      (cfg_run),
  .cfg_cap_mode (cfg_cap_mode),
  .cfg_irq_en   (cfg_irq_en),
  .wr_cnt_lo    (wr_cnt_lo),
  .wr_cnt_hi    (wr_cnt_hi),
  .clr_flag_hi  (clr_flag_hi),
  .step         (step),
  .cap_evt      (cap_evt),
  .cnt_val      (cnt_val),
  .rld_val      (rld_val),
  .flag_hi      (flag_hi),
  .flag_lo      (flag_lo),
  .irq          (irq)
);

// File: tb/sim_rcap_timer.sv
`timescale 1ns/1ps
module sim_rcap_timer;

  logic        clk;
  logic        rst_n;
  logic        rt_fast_tick, rt_slow_tick, cap_in;
  logic [1:0]  cfg_clk_sel;
  logic        cfg_run, cfg_cap_mode;
  logic [1:0]  cfg_edge_sel;
  logic        cfg_lo_irq_en, cfg_irq_en;
  logic [7:0]  wr_data;
  logic        wr_cnt_lo, wr_cnt_hi, wr_rld_lo, wr_rld_hi;
  logic        clr_flag_hi, clr_flag_lo;
  logic [15:0] cnt_val, rld_val;
  logic        flag_hi, flag_lo, irq;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // reference state
  logic        m_r1, m_r2, m_s1, m_s2, m_s3;
  int          m_pre;
  logic [15:0] m_cnt, m_rld;
  logic        m_fh, m_fl;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  rcap_timer u0 (
    .clk(clk), .rst_n(rst_n), .rt_fast_tick(rt_fast_tick), .rt_slow_tick(rt_slow_tick),
    .cap_in(cap_in), .cfg_clk_sel(cfg_clk_sel), .cfg_run(cfg_run), .cfg_cap_mode(cfg_cap_mode),
    .cfg_edge_sel(cfg_edge_sel), .cfg_lo_irq_en(cfg_lo_irq_en), .cfg_irq_en(cfg_irq_en),
    .wr_data(wr_data), .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi), .wr_rld_lo(wr_rld_lo),
    .wr_rld_hi(wr_rld_hi), .clr_flag_hi(clr_flag_hi), .clr_flag_lo(clr_flag_lo),
    .cnt_val(cnt_val), .rld_val(rld_val), .flag_hi(flag_hi), .flag_lo(flag_lo), .irq(irq)
  );

  function automatic logic exp_tick();
    case (cfg_clk_sel)
      2'd0: return 1'b1;
      2'd1: return m_pre == 11;
      2'd2: return rt_fast_tick;
      default: return rt_slow_tick;
    endcase
  endfunction

  function automatic logic exp_irq();
    return cfg_irq_en & (m_fh | (m_fl & cfg_lo_irq_en));
  endfunction

  // advance the reference by one clock edge using the inputs now applied
  task automatic model_edge();
    logic cwr, adv, cap, shi, slo;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pre = 0;
      m_cnt = 0; m_rld = 0; m_fh = 0; m_fl = 0;
      return;
    end
    if (!m_r2) begin
      m_r2 = m_r1; m_r1 = 1;
      return;
    end
    cwr = wr_cnt_lo | wr_cnt_hi;
    adv = cfg_run & exp_tick() & ~cwr;
    cap = cfg_cap_mode & ((m_s2 & ~m_s3 & cfg_edge_sel[0]) | (~m_s2 & m_s3 & cfg_edge_sel[1]));
    shi = cap | (adv & ~cfg_cap_mode & (m_cnt == 16'hFFFF));
    slo = adv & (cfg_cap_mode ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF));
    m_fh = shi | (m_fh & ~clr_flag_hi);
    m_fl = slo | (m_fl & ~clr_flag_lo);
    if (cap) m_rld_next_cap();
    else begin
      if (wr_rld_lo) m_rld[7:0]  = wr_data;
      if (wr_rld_hi) m_rld[15:8] = wr_data;
    end
    if (cwr) begin
      if (wr_cnt_lo) m_cnt[7:0]  = wr_data;
      if (wr_cnt_hi) m_cnt[15:8] = wr_data;
    end else if (adv) begin
      if (!cfg_cap_mode && m_cnt == 16'hFFFF) m_cnt = m_rld_old;
      else m_cnt = m_cnt + 16'd1;
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    m_pre = (m_pre == 11) ? 0 : m_pre + 1;
  endtask

  logic [15:0] m_rld_old;
  logic [15:0] m_cnt_old;
  task automatic m_rld_next_cap();
    m_rld = m_cnt_old;
  endtask

  task automatic check1(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check1("cnt_val", cnt_val, m_cnt);
    check1("rld_val", rld_val, m_rld);
    check1("flag_hi", {15'd0, flag_hi}, {15'd0, m_fh});
    check1("flag_lo", {15'd0, flag_lo}, {15'd0, m_fl});
    check1("irq", {15'd0, irq}, {15'd0, exp_irq()});
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic cycle();
    m_rld_old = m_rld;
    m_cnt_old = m_cnt;
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic idle_strobes();
    wr_cnt_lo = 0; wr_cnt_hi = 0; wr_rld_lo = 0; wr_rld_hi = 0;
    clr_flag_hi = 0; clr_flag_lo = 0;
  endtask

  task automatic rand_cycle(int p_wr, int p_tog, int p_clr);
    idle_strobes();
    rt_fast_tick = ($urandom_range(2) == 0);
    rt_slow_tick = ($urandom_range(9) == 0);
    if ($urandom_range(99) < p_tog) cap_in = ~cap_in;
    wr_data = 8'($urandom);
    if ($urandom_range(99) < p_wr) begin
      case ($urandom_range(3))
        0: wr_cnt_lo = 1;
        1: wr_cnt_hi = 1;
        2: wr_rld_lo = 1;
        default: wr_rld_hi = 1;
      endcase
    end
    if ($urandom_range(99) < p_clr) clr_flag_hi = 1;
    if ($urandom_range(99) < p_clr) clr_flag_lo = 1;
    cycle();
  endtask

  task automatic write16(logic is_cnt, logic [15:0] v);
    idle_strobes(); wr_data = v[7:0];
    if (is_cnt) wr_cnt_lo = 1; else wr_rld_lo = 1;
    cycle();
    idle_strobes(); wr_data = v[15:8];
    if (is_cnt) wr_cnt_hi = 1; else wr_rld_hi = 1;
    cycle();
    idle_strobes();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    rst_n = 0; rt_fast_tick = 0; rt_slow_tick = 0; cap_in = 0;
    cfg_clk_sel = 0; cfg_run = 0; cfg_cap_mode = 0; cfg_edge_sel = 0;
    cfg_lo_irq_en = 0; cfg_irq_en = 1; wr_data = 0;
    idle_strobes();
    m_rld_old = 0; m_cnt_old = 0;
    model_edge();
    // R1: reset values
    cur_req = "R1";
    repeat (3) cycle();
    rst_n = 1;
    repeat (4) cycle();

    // R2: every tick source, reload mode, counting
    cur_req = "R2";
    cfg_run = 1;
    for (int k = 0; k < 16; k++) begin
      cfg_clk_sel = 2'(k % 4);
      for (int j = 0; j < 60; j++) rand_cycle(0, 0, 0);
    end

    // R3: overflow reloads, including reload value 0xFFFF
    cur_req = "R3";
    cfg_clk_sel = 0;
    write16(0, 16'h1234);
    write16(1, 16'hFFF0);
    for (int j = 0; j < 40; j++) rand_cycle(0, 0, 0);
    write16(0, 16'hFFFF);
    for (int j = 0; j < 10; j++) rand_cycle(0, 0, 0);

    // R4: low-byte wraps and the low interrupt enable
    cur_req = "R4";
    write16(0, 16'h00F0);
    for (int j = 0; j < 600; j++) begin
      cfg_lo_irq_en = (j / 100) % 2 == 1;
      rand_cycle(0, 0, 3);
    end

    // R5 / R7: capture on every edge selection
    cfg_cap_mode = 1;
    for (int k = 0; k < 8; k++) begin
      cfg_edge_sel = 2'(k % 4);
      cur_req = (k % 4 == 0) ? "R7" : "R5";
      for (int j = 0; j < 150; j++) rand_cycle(0, 20, 5);
    end

    // R6: full wrap in capture mode
    cur_req = "R6";
    cfg_edge_sel = 3;
    write16(1, 16'hFFF8);
    for (int j = 0; j < 30; j++) rand_cycle(0, 0, 0);

    // R8: stopped counter still captures
    cur_req = "R8";
    cfg_run = 0;
    for (int j = 0; j < 300; j++) rand_cycle(0, 25, 5);
    cfg_run = 1;

    // R9: capture against reload writes, set against clear
    cur_req = "R9";
    for (int j = 0; j < 800; j++) rand_cycle(60, 40, 50);

    // R7: edges ignored in reload mode
    cur_req = "R7";
    cfg_cap_mode = 0;
    for (int j = 0; j < 300; j++) rand_cycle(5, 40, 2);

    // R10 / R11 / R12: everything random
    for (int k = 0; k < 40; k++) begin
      cur_req = (k % 3 == 0) ? "R10" : (k % 3 == 1) ? "R11" : "R12";
      cfg_clk_sel   = 2'($urandom);
      cfg_run       = ($urandom_range(4) != 0);
      cfg_cap_mode  = 1'($urandom);
      cfg_edge_sel  = 2'($urandom);
      cfg_lo_irq_en = 1'($urandom);
      cfg_irq_en    = 1'($urandom);
      for (int j = 0; j < 200; j++) rand_cycle(15, 15, 8);
    end

    // R1 again: asynchronous reset mid-run
    cur_req = "R1";
    rst_n = 0;
    repeat (2) cycle();
    rst_n = 1;
    repeat (5) cycle();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule